// File: doc/BRIEF.md
# Edge-Counted Two-Wire Serial Shifter

This block is the shift engine of a two-wire bus master. An external timer supplies a strobe, and each strobe toggles the block's own clock line, so every strobe makes one SCL edge. A data register shifts out MSB first. Each falling edge puts the current top bit on SDA. Each rising edge samples the SDA line into the bottom bit. A small edge counter counts both kinds of edge. When it wraps, it raises a sticky overflow flag, copies the data register into a buffer register, and stretches SCL low until software clears the flag.

The counter's start value sets the transfer length. Starting from 0 moves a whole byte in 16 edges. Starting from 14 moves one bit in 2 edges, which is how an acknowledge is read. To read an acknowledge, load the data register with 8'h80. The top bit of 1 releases SDA, and after the sample the register reads 8'h00 if the target pulled SDA low. An address byte is the 7-bit address followed by a 0 write bit, so address 7'h6A goes out as 8'hD4.

START and STOP conditions are not produced by the shifter. Software makes them with two override inputs, each of which forces one line low. Both lines are open-drain: an output enable of 1 pulls the line low.

Top module: `tws_shifter`

## Requirements
- R1: Each accepted strobe toggles the internal SCL level and adds one to the 4-bit edge counter, whether the edge is rising or falling.
- R2: An edge taken while the counter holds 15 wraps it to 0 and sets the sticky overflow flag. From a start value of 0, 16 edges (8 SCL pulses) end a byte.
- R3: A start value of 14 overflows after exactly two edges. With the data register loaded with 8'h80, the register then reads 8'h00 when the target held SDA low, and 8'h01 when it did not.
- R4: Data leaves MSB first. On a falling edge, the data register's top bit is latched as the SDA level (sda_oe = inverse of that bit). On a rising edge, the register shifts left and sda_in enters bit 0. The internal SDA level never changes while SCL stays high.
- R5: Strobes are accepted only when the control word has its mode field (bits 3:2) at 2'b10 (two-wire) and its clock-source field (bits 1:0) at 2'b01 (timer strobe). Any other value makes strobes have no effect on the counter, the data register or SCL.
- R6: A pulse on ovf_clr clears the overflow flag. If an overflow happens in the same cycle, the set takes priority.
- R7: On the overflow edge, the buffer register takes the data register's value as updated by that edge.
- R8: While the overflow flag is set, scl_oe is 1 (SCL held low), strobes are ignored, and the counter and data register keep their values.
- R9: man_sda_low and man_scl_low each force their line's enable to 1 at once, and have no effect on the counter or the shift state.
- R10: After reset the counter, flag, data and buffer registers and the control word are 0, and both enables are 0 (lines released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 4 | Control word: bits 3:2 mode, bits 1:0 clock source |
| dat_we | input | 1 | Write strobe for the data register |
| dat_wdata | input | 8 | Data register write value |
| cnt_we | input | 1 | Write strobe for the edge counter |
| cnt_wdata | input | 4 | Edge counter start value |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| tick | input | 1 | Timer compare strobe, one SCL edge per pulse |
| sda_in | input | 1 | Sampled SDA line level |
| man_sda_low | input | 1 | Manual override pulling SDA low |
| man_scl_low | input | 1 | Manual override pulling SCL low |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| dat_q | output | 8 | Data register |
| buf_q | output | 8 | Buffer register |
| cnt_q | output | 4 | Edge counter |
| ovf_q | output | 1 | Sticky overflow flag |

## Verification
The bench uses the default widths: an 8-bit data register and a 4-bit counter. With these widths a full byte fills the counter exactly and a start value of 14 gives the two-edge acknowledge window, so the address-byte, read-byte, ACK and NACK cases can all be reached in a few hundred cycles. The same widths let the bench reach the wrap cycle with a clear pulse applied to it, strobes arriving during the clock stretch, and strobes under both rejected control words.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    WM_IDLE  = 2'b00,
    WM_THREE = 2'b01,
    WM_TWO   = 2'b10,
    WM_RSVD  = 2'b11
  } wire_mode_e;

  typedef enum logic [1:0] {
    CS_NONE  = 2'b00,
    CS_TIMER = 2'b01,
    CS_XPOS  = 2'b10,
    CS_XNEG  = 2'b11
  } clk_src_e;

  typedef struct packed {
    wire_mode_e mode;
    clk_src_e   src;
  } ctl_word_t;
endpackage

// File: rtl/tws_ctl.sv
module tws_ctl
  import tws_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [3:0] wdata,
  output logic       clk_en
);
  ctl_word_t ctl_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_r <= '0;
    else if (we) ctl_r <= ctl_word_t'(wdata);
  end

  assign clk_en = (ctl_r.mode == WM_TWO) && (ctl_r.src == CS_TIMER);
endmodule

// File: rtl/tws_edgecnt.sv
module tws_edgecnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_ev,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic          ovf,
  output logic          wrap_ev
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  function automatic logic [CW-1:0] step_cnt(input logic [CW-1:0] c);
    return c + 1'b1;
  endfunction

  assign wrap_ev = edge_ev && (cnt == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (ld) cnt <= ld_val;
      else if (edge_ev) cnt <= step_cnt(cnt);
      if (wrap_ev) ovf <= 1'b1;
      else if (clr) ovf <= 1'b0;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev && !ld |=> cnt == $past(cnt) + 1'b1); // R1
  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> ovf && (cnt == '0 || $past(ld))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !wrap_ev |=> !ovf); // R6
endmodule

// File: rtl/tws_shreg.sv
module tws_shreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_ev,
  input  logic          rise_ev,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic          sda_in,
  input  logic          wrap_ev,
  output logic [DW-1:0] dat,
  output logic [DW-1:0] buff,
  output logic          sda_bit
);
  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] d, input logic b);
    return {d[DW-2:0], b};
  endfunction

  logic [DW-1:0] dat_nxt;
  assign dat_nxt = rise_ev ? shift_in(dat, sda_in) : dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat     <= '0;
      buff    <= '0;
      sda_bit <= 1'b1;
    end else begin
      dat <= ld ? ld_val : dat_nxt;
      if (wrap_ev) buff <= dat_nxt;
      if (fall_ev) sda_bit <= dat[DW-1];
    end
  end

  AST_BUF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev && !ld |=> buff == dat); // R7
  AST_MSB_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> sda_bit == $past(dat[DW-1])); // R4
endmodule

// File: rtl/tws_shifter.sv
module tws_shifter #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [3:0]    ctl_wdata,
  input  logic          dat_we,
  input  logic [DW-1:0] dat_wdata,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          ovf_clr,
  input  logic          tick,
  input  logic          sda_in,
  input  logic          man_sda_low,
  input  logic          man_scl_low,
  output logic          sda_oe,
  output logic          scl_oe,
  output logic [DW-1:0] dat_q,
  output logic [DW-1:0] buf_q,
  output logic [CW-1:0] cnt_q,
  output logic          ovf_q
);
  logic clk_en, active, edge_ev, fall_ev, rise_ev, wrap_ev;
  logic scl_lvl, sda_bit;

  tws_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .clk_en(clk_en)
  );

  assign active  = clk_en && !ovf_q;
  assign edge_ev = active && tick;
  assign fall_ev = edge_ev && scl_lvl;
  assign rise_ev = edge_ev && !scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_lvl <= 1'b1;
    else if (edge_ev) scl_lvl <= !scl_lvl;
  end

  tws_edgecnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .edge_ev(edge_ev), .ld(cnt_we), .ld_val(cnt_wdata),
    .clr(ovf_clr), .cnt(cnt_q), .ovf(ovf_q), .wrap_ev(wrap_ev)
  );

  tws_shreg #(.DW(DW)) u_sh (
    .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .rise_ev(rise_ev), .ld(dat_we),
    .ld_val(dat_wdata), .sda_in(sda_in), .wrap_ev(wrap_ev), .dat(dat_q),
    .buff(buf_q), .sda_bit(sda_bit)
  );

  assign sda_oe = !sda_bit || man_sda_low;
  assign scl_oe = !scl_lvl || ovf_q || man_scl_low;

  AST_SDA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    scl_lvl && $past(scl_lvl) |-> $stable(sda_bit)); // R4
  AST_STRETCH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !cnt_we && !dat_we |=> $stable(cnt_q) && $stable(dat_q) && $stable(scl_lvl)); // R8
  AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en && !cnt_we && !dat_we |=> $stable(scl_lvl) && $stable(cnt_q) && $stable(dat_q)); // R5
endmodule

// File: tb/sim_tws_shifter.sv
module sim_tws_shifter;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, dat_we = 0, cnt_we = 0, ovf_clr = 0, tick = 0;
  logic [3:0] ctl_wdata = 0, cnt_wdata = 0;
  logic [7:0] dat_wdata = 0;
  logic man_sda_low = 0, man_scl_low = 0, tgt_low = 0;
  logic sda_in, sda_oe, scl_oe, ovf_q;
  logic [7:0] dat_q, buf_q;
  logic [3:0] cnt_q;
  int checks = 0, errors = 0;
  int m_cnt, m_ovf, m_dr, m_buf, m_sdab, m_scl, m_mode, m_src;

  always #5 clk = !clk;
  assign sda_in = !(sda_oe || tgt_low);

  tws_shifter u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .dat_we(dat_we),
    .dat_wdata(dat_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr),
    .tick(tick), .sda_in(sda_in), .man_sda_low(man_sda_low), .man_scl_low(man_scl_low),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .dat_q(dat_q), .buf_q(buf_q), .cnt_q(cnt_q), .ovf_q(ovf_q)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    int ncnt, ndr, nbuf, nsdab, novf, nscl, sh;
    bit e, wrap;
    if (!rst_n) begin
      m_cnt = 0; m_ovf = 0; m_dr = 0; m_buf = 0; m_sdab = 1; m_scl = 1; m_mode = 0; m_src = 0;
    end else begin
      e = (m_mode == 2) && (m_src == 1) && (m_ovf == 0) && tick;
      wrap = e && (m_cnt == 15);
      sh = (e && m_scl == 0) ? (((m_dr << 1) | int'(sda_in)) & 255) : m_dr;
      ncnt = cnt_we ? int'(cnt_wdata) : (e ? (m_cnt + 1) % 16 : m_cnt);
      ndr = dat_we ? int'(dat_wdata) : sh;
      nbuf = wrap ? sh : m_buf;
      nsdab = (e && m_scl == 1) ? (m_dr >> 7) & 1 : m_sdab;
      novf = wrap ? 1 : (ovf_clr ? 0 : m_ovf);
      nscl = e ? 1 - m_scl : m_scl;
      if (ctl_we) begin m_mode = int'(ctl_wdata[3:2]); m_src = int'(ctl_wdata[1:0]); end
      m_cnt = ncnt; m_dr = ndr; m_buf = nbuf; m_sdab = nsdab; m_ovf = novf; m_scl = nscl;
    end
  end

  // cycle compare, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 counter", int'(cnt_q), m_cnt);
      check("R2 overflow flag", int'(ovf_q), m_ovf);
      check("R4 data register", int'(dat_q), m_dr);
      check("R7 buffer", int'(buf_q), m_buf);
      check("R4 sda_oe", int'(sda_oe), int'(m_sdab == 0 || man_sda_low));
      check("R8 scl_oe", int'(scl_oe), int'(m_scl == 0 || m_ovf == 1 || man_scl_low));
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic pulse_tick(int gap);
    @(negedge clk); #2 tick = 1;
    @(negedge clk); #2 tick = 0;
    if (gap > 0) cyc(gap);
  endtask

  task automatic wr_ctl(logic [3:0] v);
    @(negedge clk); #2 ctl_we = 1; ctl_wdata = v;
    @(negedge clk); #2 ctl_we = 0;
  endtask

  task automatic load(logic [7:0] d, logic [3:0] c);
    @(negedge clk); #2 dat_we = 1; dat_wdata = d; cnt_we = 1; cnt_wdata = c;
    @(negedge clk); #2 dat_we = 0; cnt_we = 0;
  endtask

  task automatic clear_ovf();
    @(negedge clk); #2 ovf_clr = 1;
    @(negedge clk); #2 ovf_clr = 0;
  endtask

  initial begin
    logic [7:0] seen;
    logic [7:0] pat;
    cyc(3);
    // R10 reset state
    check("R10 reset cnt", int'(cnt_q), 0);
    check("R10 reset ovf", int'(ovf_q), 0);
    check("R10 reset lines", int'({sda_oe, scl_oe}), 0);
    check("R10 reset data", int'(dat_q), 0);
    rst_n = 1;
    cyc(1);
    // R5: control word 0 and a wrong clock source both ignore strobes
    load(8'hA5, 4'd3);
    for (int i = 0; i < 3; i++) pulse_tick(1);
    check("R5 ignored cnt (ctl 0)", int'(cnt_q), 3);
    check("R5 ignored scl (ctl 0)", int'(scl_oe), 0);
    wr_ctl(4'b1000);
    for (int i = 0; i < 3; i++) pulse_tick(0);
    check("R5 ignored data (ctl 1000)", int'(dat_q), 8'hA5);
    // address byte 7'h6A + write = 8'hD4
    wr_ctl(4'b1001);
    load(8'hD4, 4'd0);
    @(negedge clk); #2 man_sda_low = 1;
    @(negedge clk);
    check("R9 START sda low scl high", int'({sda_oe, scl_oe}), 2);
    #2 man_scl_low = 1;
    cyc(1);
    check("R9 override leaves counter", int'(cnt_q), 0);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      pulse_tick(1);
      if (i == 0) begin man_sda_low = 0; man_scl_low = 0; end
      #1 seen = {seen[6:0], !sda_oe};
      pulse_tick(2);
    end
    check("R4 address bits MSB first", int'(seen), 8'hD4);
    check("R2 byte ends in overflow", int'(ovf_q), 1);
    check("R8 stretch after byte", int'(scl_oe), 1);
    check("R7 buffer holds byte", int'(buf_q), 8'hD4);
    for (int i = 0; i < 3; i++) pulse_tick(0);
    check("R8 strobes ignored in stretch", int'(cnt_q), 0);
    clear_ovf();
    check("R6 clear drops flag", int'(ovf_q), 0);
    // R3 acknowledge read: target pulls low
    load(8'h80, 4'd14);
    pulse_tick(1);
    tgt_low = 1;
    pulse_tick(1);
    tgt_low = 0;
    check("R3 ack reads zero", int'(dat_q), 0);
    check("R3 two edges overflow", int'(ovf_q), 1);
    clear_ovf();
    // R3 no acknowledge
    load(8'h80, 4'd14);
    pulse_tick(0);
    pulse_tick(0);
    check("R3 nack reads one", int'(dat_q), 1);
    clear_ovf();
    // read byte 8'h3C, clear pulse on the wrap cycle
    pat = 8'h3C;
    load(8'hFF, 4'd0);
    for (int i = 0; i < 8; i++) begin
      pulse_tick(0);
      tgt_low = !pat[7-i];
      if (i == 7) begin
        @(negedge clk); #2 tick = 1; ovf_clr = 1;
        @(negedge clk); #2 tick = 0; ovf_clr = 0;
      end else pulse_tick(1);
    end
    tgt_low = 0;
    check("R4 sampled byte", int'(dat_q), 8'h3C);
    check("R6 set wins over clear", int'(ovf_q), 1);
    check("R7 buffer holds read byte", int'(buf_q), 8'h3C);
    cyc(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule